// File: doc/BRIEF.md
# Direct-Mapped Block Cache with Write-Through Stores

This block sits between a processor's load/store port and a slower memory. It keeps 1024 lines. Each line holds an 18-bit tag, a valid flag and a block of four 32-bit words, which is 16 KB of data in total. The processor issues one word access at a time by byte address and holds it until the stall output drops. A read that finds its line returns the word in the same cycle without touching memory.

A read that misses fetches the whole aligned block from memory as a four-beat burst paced by a ready input. It then installs the block and the new tag, and returns the requested word. Every store is forwarded to memory as one word write, so the cache never holds data that memory lacks. A store that misses first refills the whole block and then overlays the stored word on it.

Top module: `dm_block_cache`

## Requirements
- R1: The byte address splits into tag = bits 31:14, line index = bits 13:4 and word select = bits 3:2. The word select picks one of the four words of the line. Bits 1:0 have no effect on any access.
- R2: An access hits only when the indexed line is valid and its stored tag equals the address tag. A read hit drops `cpu_stall` in the cycle it is presented, reports `cpu_hit`=1, returns the cached word and issues no memory request.
- R3: A read miss to an invalid line issues four read beats on `mem_addr`. The beats keep the request's tag and index, carry word number 0, 1, 2, 3 in bits 3:2 with bits 1:0 zero, and advance only on `mem_ready`. The line is then installed, and the access completes with `cpu_hit`=0 and the addressed word.
- R4: A miss to a valid line with a different tag discards the old block and tag. A later access with the old tag misses.
- R5: Every store completes in the cycle of exactly one memory write beat (`mem_we`=1) that carries the word-aligned store address and the store data. A store hit also updates the cached word.
- R6: A store miss first refills all four words from memory, then merges the stored word into the installed line. Later reads of that line hit, return the stored word at its position and return memory data elsewhere.
- R7: `cpu_stall` is high while a presented request is unfinished and low in its completion cycle. With no request it is low and no memory request is made.
- R8: Synchronous active-high `rst` invalidates all lines, so the first access to any address after reset misses.
- R9: From a cold cache, reads of 0x14, 0x1C, 0x34 and 0x8014 give miss, hit, miss, miss. The last one replaces line 1 (tag 0 by tag 2), so a following read of 0x14 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held with its fields until `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the request completes |
| cpu_stall | output | 1 | Request not yet complete |
| cpu_hit | output | 1 | At completion: 1 if no refill was needed |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat, 0 = refill read beat |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Memory accepts or delivers the current beat |
| mem_rdata | input | 32 | Refill read data for the current beat |

## Verification
The bench goes after tag conflicts that share an index: the documented four-read sequence, a tag differing only in bit 14, and the re-read of an evicted tag. A design that ignored the valid flag or compared too few tag bits would report hits there and return stale words. Store misses are checked word by word after the refill, so a merge that is lost, or applied before the burst overwrites it, shows up as a wrong word. Refills are also run against a memory that withholds ready on some cycles, which exposes beat counters that advance without a handshake. A reset in mid-run followed by a read of a resident line catches valid flags that survive reset.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
    parameter int ADDR_W     = 32;
    parameter int WORD_W     = 32;
    parameter int LINE_WORDS = 4;
    parameter int LINES      = 1024;

    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W;

    typedef logic [WORD_W-1:0]                  word_t;
    typedef logic [LINE_WORDS-1:0][WORD_W-1:0]  line_t;
    typedef logic [TAG_W-1:0]                   tag_t;
    typedef logic [IDX_W-1:0]                   idx_t;
    typedef logic [WSEL_W-1:0]                  wsel_t;

    typedef struct packed {
        tag_t                tag;
        idx_t                idx;
        wsel_t               wsel;
        logic [BYTE_W-1:0]   byt;
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    localparam wsel_t LAST_BEAT = wsel_t'(LINE_WORDS - 1);

    function automatic line_t put_word(line_t l, wsel_t sel, word_t w);
        line_t r;
        r      = l;
        r[sel] = w;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] beat_addr(addr_t a, wsel_t beat);
        return {a.tag, a.idx, beat, {BYTE_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
`timescale 1ns/1ps
module dmc_tag_store
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output logic rd_valid,
    output tag_t rd_tag,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  tag_t wr_tag
);
    logic [LINES-1:0] valid_q;
    tag_t             tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            tag_q[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
`timescale 1ns/1ps
module dmc_data_store
    import dmc_pkg::*;
(
    input  logic  clk,
    input  logic  line_we,
    input  logic  word_we,
    input  idx_t  wr_idx,
    input  wsel_t wr_sel,
    input  line_t line_in,
    input  word_t word_in,
    input  idx_t  rd_idx,
    output line_t rd_line
);
    line_t mem_q [LINES];

    always_ff @(posedge clk) begin
        if (line_we)
            mem_q[wr_idx] <= line_in;
        else if (word_we)
            mem_q[wr_idx][wr_sel] <= word_in;
    end

    assign rd_line = mem_q[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  word_t             cpu_wdata,
    input  logic              lookup_hit,
    output logic              cpu_stall,
    output logic              cpu_hit,
    output logic              line_we,
    output logic              word_we,
    output line_t             fill_line,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output word_t             mem_wdata,
    input  logic              mem_ready,
    input  word_t             mem_rdata
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((1 << BYTE_W) - 1);

    addr_t  a;
    state_e state_q, state_d;
    wsel_t  beat_q;
    logic   missed_q;
    line_t  fill_q;
    logic   done;

    assign a = cpu_addr;

    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        line_we = 1'b0;
        word_we = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!lookup_hit) begin
                        state_d = ST_FILL;
                    end else if (cpu_we) begin
                        word_we = 1'b1;
                        state_d = ST_WRITE;
                    end else begin
                        done = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready && beat_q == LAST_BEAT) begin
                    line_we = 1'b1;
                    state_d = cpu_we ? ST_WRITE : ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        line_t raw;
        raw            = fill_q;
        raw[LAST_BEAT] = mem_rdata;
        fill_line      = cpu_we ? put_word(raw, a.wsel, cpu_wdata) : raw;
    end

    assign mem_addr  = (state_q == ST_WRITE) ? (cpu_addr & WORD_MASK)
                                             : beat_addr(a, beat_q);
    assign mem_wdata = cpu_wdata;
    assign cpu_stall = cpu_req & ~done;
    assign cpu_hit   = ~missed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            missed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL && mem_ready)
                beat_q <= beat_q + 1'b1;
            if (state_q == ST_IDLE && cpu_req && !lookup_hit)
                missed_q <= 1'b1;
            else if (done)
                missed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_FILL && mem_ready)
            fill_q[beat_q] <= mem_rdata;
    end
endmodule

// File: rtl/dm_block_cache.sv
`timescale 1ns/1ps
module dm_block_cache
    import dmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_stall,
    output logic        cpu_hit,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata
);
    addr_t a;
    logic  rd_valid;
    tag_t  rd_tag;
    line_t rd_line;
    line_t fill_line;
    logic  lookup_hit;
    logic  line_we;
    logic  word_we;

    assign a          = cpu_addr;
    assign lookup_hit = rd_valid && (rd_tag == a.tag);
    assign cpu_rdata  = rd_line[a.wsel];

    dmc_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (a.idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .wr_en    (line_we),
        .wr_idx   (a.idx),
        .wr_tag   (a.tag)
    );

    dmc_data_store u_data (
        .clk     (clk),
        .line_we (line_we),
        .word_we (word_we),
        .wr_idx  (a.idx),
        .wr_sel  (a.wsel),
        .line_in (fill_line),
        .word_in (cpu_wdata),
        .rd_idx  (a.idx),
        .rd_line (rd_line)
    );

    dmc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .lookup_hit (lookup_hit),
        .cpu_stall  (cpu_stall),
        .cpu_hit    (cpu_hit),
        .line_we    (line_we),
        .word_we    (word_we),
        .fill_line  (fill_line),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata)
    );
endmodule

// File: rtl/dm_block_cache_chk.sv
`timescale 1ns/1ps
module dm_block_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [31:2] cpu_waddr,
    input logic [31:0] cpu_wdata,
    input logic        cpu_stall,
    input logic        cpu_hit,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready
);
    // R3
    fill_block_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr[31:4] == cpu_waddr[31:4] && mem_addr[1:0] == 2'b00));

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !mem_ready) |=> (mem_req && !mem_we && $stable(mem_addr)));

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready && mem_addr[3:2] != 2'd3)
        |=> (mem_req && !mem_we && mem_addr[3:2] == ($past(mem_addr[3:2]) + 2'd1)));

    // R5
    store_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == {cpu_waddr, 2'b00} && mem_wdata == cpu_wdata));

    // R5
    store_done_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall) |-> (mem_req && mem_we && mem_ready));

    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && !cpu_stall && cpu_hit) |-> !mem_req);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |-> (!mem_req && !cpu_stall));
endmodule

bind dm_block_cache dm_block_cache_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_waddr (cpu_addr[31:2]),
    .cpu_wdata (cpu_wdata),
    .cpu_stall (cpu_stall),
    .cpu_hit   (cpu_hit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/dm_block_cache_tb.sv
`timescale 1ns/1ps
module dm_block_cache_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        cpu_hit;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    dm_block_cache u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .cpu_hit(cpu_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // backing memory and behavioural cache model
    logic [31:0] bmem [int unsigned];
    bit          m_valid [1024];
    logic [17:0] m_tag   [1024];
    logic [31:0] m_data  [1024][4];

    int          rd_beats = 0;
    int          wr_beats = 0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    int          rdy_cnt = 0;
    bit          slow_mem = 0;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        int unsigned k = {a[31:2], 2'b00};
        if (bmem.exists(k)) return bmem[k];
        return {a[15:0] ^ 16'hC35A, a[31:16] + 16'h1357};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // memory responder: drives at the falling edge
    always @(negedge clk) begin
        rdy_cnt++;
        if (mem_req) begin
            mem_ready = slow_mem ? (rdy_cnt % 3 != 0) : 1'b1;
            mem_rdata = mem_word(mem_addr);
            if (mem_ready && !mem_we) rd_beats++;
            if (mem_ready && mem_we) begin
                bmem[int'({mem_addr[31:2], 2'b00})] = mem_wdata;
                wr_beats++;
                last_wr_addr = mem_addr;
                last_wr_data = mem_wdata;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) m_valid[i] = 0;
    endtask

    // one processor access, checked against the model
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input string req, output int cycles);
        int idx = int'(addr[13:4]);
        int w   = int'(addr[3:2]);
        bit exp_hit;
        logic [31:0] exp_rd;
        int rb0, wb0;
        exp_hit = m_valid[idx] && (m_tag[idx] == addr[31:14]);
        if (!exp_hit) begin
            for (int k = 0; k < 4; k++)
                m_data[idx][k] = mem_word({addr[31:4], 4'b0000} + 32'(k * 4));
            m_valid[idx] = 1;
            m_tag[idx]   = addr[31:14];
        end
        if (we) m_data[idx][w] = wd;
        exp_rd = m_data[idx][w];
        rb0 = rd_beats;
        wb0 = wr_beats;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        cycles = 0;
        forever begin
            #2;
            if (!cpu_stall) break;
            cycles++;
            @(negedge clk);
        end
        chk(cpu_hit == exp_hit, req, $sformatf("hit flag @%h", addr), 32'(cpu_hit), 32'(exp_hit));
        if (!we) chk(cpu_rdata == exp_rd, req, $sformatf("read data @%h", addr), cpu_rdata, exp_rd);
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        chk(rd_beats - rb0 == (exp_hit ? 0 : 4), req, $sformatf("refill beats @%h", addr),
            32'(rd_beats - rb0), exp_hit ? 32'd0 : 32'd4);
        chk(wr_beats - wb0 == (we ? 1 : 0), req, $sformatf("write beats @%h", addr),
            32'(wr_beats - wb0), we ? 32'd1 : 32'd0);
        if (we) begin
            chk(last_wr_addr == {addr[31:2], 2'b00}, req, "write-through address",
                last_wr_addr, {addr[31:2], 2'b00});
            chk(last_wr_data == wd, req, "write-through data", last_wr_data, wd);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int cyc;
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R7 R8: quiet after reset
        chk(cpu_stall == 1'b0, "R7", "stall after reset", 32'(cpu_stall), 32'd0);
        chk(mem_req == 1'b0, "R8", "mem_req after reset", 32'(mem_req), 32'd0);

        // R9: documented sequence; R3 cold miss, R2 hit, R4 replacement
        access(0, 32'h0000_0014, 0, "R9", cyc);
        access(0, 32'h0000_001C, 0, "R9", cyc);
        chk(cyc == 0, "R2", "hit completes in first cycle", 32'(cyc), 32'd0);
        access(0, 32'h0000_0034, 0, "R9", cyc);
        access(0, 32'h0000_8014, 0, "R9", cyc);
        access(0, 32'h0000_0014, 0, "R4", cyc);
        access(0, 32'h0000_001C, 0, "R4", cyc);

        // R1: byte bits ignored, bit 14 is tag
        access(0, 32'h0000_0017, 0, "R1", cyc);
        access(0, 32'h0000_0019, 0, "R1", cyc);
        access(0, 32'h0000_4014, 0, "R1", cyc);
        access(0, 32'h0000_0010, 0, "R1", cyc);

        // R5: store hit, then read back
        access(1, 32'h0000_0018, 32'hDEAD_0018, "R5", cyc);
        access(0, 32'h0000_0018, 0, "R5", cyc);
        access(0, 32'h0000_0014, 0, "R5", cyc);

        // R6: store miss refills then merges
        access(1, 32'h0002_0008, 32'hBEEF_0008, "R6", cyc);
        for (int k = 0; k < 4; k++)
            access(0, 32'h0002_0000 + 32'(k * 4), 0, "R6", cyc);
        access(1, 32'h0003_0403, 32'h1234_5678, "R6", cyc);
        access(0, 32'h0003_0400, 0, "R6", cyc);
        access(0, 32'h0003_0400, 0, "R6", cyc);

        // R7: slow memory, stall persists through refill
        slow_mem = 1;
        access(0, 32'h0005_0120, 0, "R7", cyc);
        chk(cyc >= 5, "R7", "stall cycles on slow refill", 32'(cyc), 32'd5);
        access(1, 32'h0005_0124, 32'hCAFE_0124, "R7", cyc);
        access(0, 32'h0005_0124, 0, "R7", cyc);
        access(1, 32'h0006_0128, 32'h0BAD_0128, "R7", cyc);
        access(0, 32'h0006_012C, 0, "R7", cyc);

        // mixed pattern over a few colliding indexes
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 80; i++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {12'h000, lfsr[5:4], 4'h0, 4'h0, lfsr[9:8], 4'h0, lfsr[3:0]};
            slow_mem = lfsr[12];
            access(lfsr[7] & lfsr[6], a, lfsr ^ 32'h5555_0000, (lfsr[7] & lfsr[6]) ? "R5" : "R2", cyc);
        end
        slow_mem = 0;

        // R8: reset mid-run invalidates resident lines
        access(0, 32'h0000_001C, 0, "R8", cyc);
        do_reset();
        access(0, 32'h0000_001C, 0, "R8", cyc);
        access(0, 32'h0002_0008, 0, "R8", cyc);

        summary();
    end
endmodule